// File: doc/BRIEF.md
# Transmit Collision Counter with Excessive-Collision Abort

This block tracks how many collisions occur while one outgoing frame is on the wire and decides when that frame must be abandoned. The MAC supplies three single-cycle pulses: one when a transmission begins, one for each collision it detects, and one when the transmission ends. The block keeps a 4-bit running count and shows it as an 8-bit read-only register. When the sixteenth collision arrives, it raises a one-cycle abort pulse toward the transmit status logic.

After a transmission ends, the count for that frame stays readable until the next frame starts. On the sixteenth collision the count neither saturates nor wraps without notice. It returns to zero, the abort pulse fires, and further collisions are ignored until a new frame starts.

A small state machine controls the count.
- IDLE: no frame is in flight.
- COUNT: a frame is in flight and collisions are counted.
- ABORT: the frame was abandoned and collisions are ignored.

Its transitions are as follows.
- A start pulse moves any state to COUNT.
- COUNT goes to IDLE on done.
- COUNT goes to ABORT on the sixteenth collision, unless done arrives in the same cycle, in which case it goes to IDLE.
- ABORT goes to IDLE on done.

Top module: `coll_tx_counter`

## Requirements
- R1: A transmit-start pulse in any state makes the count read zero one cycle later and enters COUNT.
- R2: In COUNT, each collision pulse raises the count by exactly one, visible the following cycle.
- R3: In IDLE (after done, or after reset), collision pulses do not change the count, and the last count stays readable.
- R4: The sixteenth collision of a frame makes the count read zero and raises the abort output for exactly one cycle, in the cycle after that collision.
- R5: In ABORT, collision pulses change neither the count nor the abort output until the next start pulse. At most one abort pulse occurs per frame.
- R6: When start and collision pulses coincide, the count reads zero next cycle and the collision is not counted.
- R7: When collision and done pulses coincide in COUNT, the collision is counted and the state returns to IDLE.
- R8: The read value carries the count in bits 3:0, and bits 7:4 always read zero.
- R9: After reset the register reads 0x00 and the abort output is low.
- R10: Host writes to the register, with any data, never change the read value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_start | input | 1 | Pulse: a new transmission begins |
| coll_det | input | 1 | Pulse: a collision was detected |
| tx_done | input | 1 | Pulse: the transmission finished |
| host_wr | input | 1 | Host write strobe aimed at the register |
| host_wr_data | input | 8 | Host write data (discarded) |
| rd_data | output | 8 | Read view: zero upper nibble, count in the lower nibble |
| abort_pulse | output | 1 | One-cycle excessive-collision abort toward transmit status |

## Verification
Two functions can fall in the same cycle. A start pulse can arrive together with a collision, and a collision can arrive together with the done pulse. The bench drives each pair in one cycle from its vector table. For start plus collision, the count must read zero the next cycle, which shows the collision was dropped. For collision plus done, the count must be one higher, and a later collision must then leave it unchanged, which shows the block went to IDLE. The sixteenth collision is also driven together with a pending start in a later frame, to confirm that start always wins.

// File: rtl/coll_pkg.sv
package coll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_ABORT = 2'd2
    } coll_state_e;

endpackage

// File: rtl/coll_fsm.sv
module coll_fsm
    import coll_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_start,
    input  logic coll_det,
    input  logic tx_done,
    input  logic cnt_at_max,
    output logic cnt_clear,
    output logic cnt_inc,
    output logic cnt_wrap,
    output logic abort_pulse
);

    coll_state_e state_q;
    coll_state_e state_d;
    logic        abort_q;

    // State register and registered abort
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            abort_q <= 1'b0;
        end else begin
            state_q <= state_d;
            abort_q <= cnt_wrap;
        end
    end

    // Next-state selection; start has priority over everything
    always_comb begin
        state_d = state_q;
        if (tx_start) begin
            state_d = ST_COUNT;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_COUNT: begin
                    if (tx_done)
                        state_d = ST_IDLE;
                    else if (cnt_wrap)
                        state_d = ST_ABORT;
                end
                ST_ABORT: begin
                    if (tx_done)
                        state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Output decode
    always_comb begin
        cnt_clear   = tx_start;
        cnt_inc     = (state_q == ST_COUNT) && coll_det && !tx_start;
        cnt_wrap    = cnt_inc && cnt_at_max;
        abort_pulse = abort_q;
    end

    AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |=> !abort_pulse); // R4

    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ABORT) && !tx_start |=> !abort_pulse); // R5

    AST_START_ENTERS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> (state_q == ST_COUNT)); // R1

    AST_DONE_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done && !tx_start |=> (state_q == ST_IDLE)); // R7

endmodule

// File: rtl/coll_counter.sv
module coll_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_clear,
    input  logic             cnt_inc,
    input  logic             cnt_wrap,
    output logic [CNT_W-1:0] count,
    output logic             cnt_at_max
);

    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (cnt_clear || cnt_wrap)
            count_q <= '0;
        else if (cnt_inc)
            count_q <= count_q + CNT_ONE;
    end

    always_comb begin
        count      = count_q;
        cnt_at_max = (count_q == CNT_TOP);
    end

    AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clear |=> (count == '0)); // R1

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_inc && !cnt_clear && (count != CNT_TOP) |=> (count == $past(count) + CNT_ONE)); // R2

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wrap |=> (count == '0)); // R4

    AST_HOLD_WITHOUT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clear && !cnt_inc |=> $stable(count)); // R3

endmodule

// File: rtl/coll_readback.sv
module coll_readback #(
    parameter int CNT_W = 4,
    parameter int REG_W = 8
) (
    input  logic [CNT_W-1:0] count,
    output logic [REG_W-1:0] rd_data
);

    localparam int PAD_W = REG_W - CNT_W;

    generate
        if (PAD_W > 0) begin : g_pad
            assign rd_data = {{PAD_W{1'b0}}, count};
        end else begin : g_nopad
            assign rd_data = count[REG_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/coll_tx_counter.sv
module coll_tx_counter #(
    parameter int CNT_W = 4,
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_start,
    input  logic             coll_det,
    input  logic             tx_done,
    input  logic             host_wr,
    input  logic [REG_W-1:0] host_wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             abort_pulse
);

    logic             cnt_clear;
    logic             cnt_inc;
    logic             cnt_wrap;
    logic             cnt_at_max;
    logic [CNT_W-1:0] count;

    coll_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_start    (tx_start),
        .coll_det    (coll_det),
        .tx_done     (tx_done),
        .cnt_at_max  (cnt_at_max),
        .cnt_clear   (cnt_clear),
        .cnt_inc     (cnt_inc),
        .cnt_wrap    (cnt_wrap),
        .abort_pulse (abort_pulse)
    );

    coll_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_clear  (cnt_clear),
        .cnt_inc    (cnt_inc),
        .cnt_wrap   (cnt_wrap),
        .count      (count),
        .cnt_at_max (cnt_at_max)
    );

    coll_readback #(.CNT_W(CNT_W), .REG_W(REG_W)) u_rb (
        .count   (count),
        .rd_data (rd_data)
    );

    AST_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && (host_wr_data != rd_data) && !tx_start && !coll_det |=> $stable(rd_data)); // R10

    AST_ABORT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> (rd_data == '0)); // R4

    AST_START_COLL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start && coll_det |=> (rd_data == '0)); // R6

endmodule

// File: tb/sim_coll_tx_counter.sv
module sim_coll_tx_counter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_start = 1'b0;
    logic       coll_det = 1'b0;
    logic       tx_done = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       abort_pulse;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    coll_tx_counter u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_start     (tx_start),
        .coll_det     (coll_det),
        .tx_done      (tx_done),
        .host_wr      (host_wr),
        .host_wr_data (host_wr_data),
        .rd_data      (rd_data),
        .abort_pulse  (abort_pulse)
    );

    // Vector: [8] start [7] coll [6] done [5] write [4:1] expected count [0] expected abort
    localparam int NVEC = 13;
    localparam logic [8:0] VEC [NVEC] = '{
        9'b1000_0000_0,  // R1 start
        9'b0100_0001_0,  // R2 coll -> 1
        9'b0100_0010_0,  // R2 coll -> 2
        9'b0100_0011_0,  // R2 coll -> 3
        9'b0000_0011_0,  // R3 quiet hold
        9'b0010_0011_0,  // R3 done, value kept
        9'b0100_0011_0,  // R3 coll in IDLE ignored
        9'b0001_0011_0,  // R10 write ignored
        9'b1100_0000_0,  // R6 start+coll -> 0
        9'b0100_0001_0,  // R2 coll -> 1
        9'b0110_0010_0,  // R7 coll+done -> 2
        9'b0100_0010_0,  // R7 now IDLE, coll ignored
        9'b1000_0000_0   // R1 start clears
    };

    task automatic check(input string req, input logic [7:0] exp_rd, input logic exp_ab);
        checks++;
        if (rd_data !== exp_rd || abort_pulse !== exp_ab) begin
            fails++;
            $display("FAIL %s: rd=%h abort=%b expected rd=%h abort=%b",
                     req, rd_data, abort_pulse, exp_rd, exp_ab);
        end
    endtask

    task automatic step(input logic s, input logic c, input logic d, input logic w);
        @(negedge clk);
        tx_start = s;
        coll_det = c;
        tx_done = d;
        host_wr = w;
        host_wr_data = w ? 8'hA5 : 8'h00;
        @(posedge clk);
        #2;
        tx_start = 1'b0;
        coll_det = 1'b0;
        tx_done = 1'b0;
        host_wr = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R9 reset", 8'h00, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5]);
            check($sformatf("R1-vec%0d R2 R3 R6 R7 R8 R10", i), {4'h0, VEC[i][4:1]}, VEC[i][0]);
        end

        // R4: fifteen collisions reach 15
        for (int k = 1; k <= 15; k++) step(1'b0, 1'b1, 1'b0, 1'b0);
        check("R2 count 15, R8 upper zero", 8'h0F, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        check("R10 write at 15", 8'h0F, 1'b0);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        check("R4 sixteenth collision aborts", 8'h00, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        check("R4 abort is one cycle", 8'h00, 1'b0);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        check("R5 collision ignored after abort", 8'h00, 1'b0);
        step(1'b0, 1'b1, 1'b1, 1'b0);
        check("R5 collision with done in ABORT", 8'h00, 1'b0);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        check("R3 IDLE after abort", 8'h00, 1'b0);

        // Start in ABORT state and count again
        step(1'b1, 1'b0, 1'b0, 1'b0);
        for (int k = 1; k <= 15; k++) step(1'b0, 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        check("R6 start+coll during ABORT", 8'h00, 1'b0);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        check("R1 counting resumes after start", 8'h01, 1'b0);

        // Sixteenth collision coincides with done
        for (int k = 2; k <= 15; k++) step(1'b0, 1'b1, 1'b0, 1'b0);
        check("R2 count 15 again", 8'h0F, 1'b0);
        step(1'b0, 1'b1, 1'b1, 1'b0);
        check("R7 sixteenth with done aborts", 8'h00, 1'b1);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        check("R7 IDLE after done", 8'h00, 1'b0);

        // Sixteenth collision hidden by a start: no abort
        step(1'b1, 1'b0, 1'b0, 1'b0);
        for (int k = 1; k <= 15; k++) step(1'b0, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        check("R6 start beats sixteenth", 8'h00, 1'b0);

        // Mid-run reset
        step(1'b0, 1'b1, 1'b0, 1'b0);
        check("R2 count 1 before reset", 8'h01, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        check("R9 reset mid-run", 8'h00, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 1'b1, 1'b0, 1'b0);
        check("R9 IDLE after reset ignores collision", 8'h00, 1'b0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule